// File: doc/BRIEF.md
# Dual-Path Single-Precision Adder

This block adds or subtracts two binary32 operands and returns a binary32 result rounded to nearest, ties to even. It runs two datapaths side by side and keeps only one result. The near datapath covers effective subtraction when the exponents differ by zero or one. In that case alignment is at most a one-bit shift, but the difference can lose many leading bits, so this path has a full leading-zero count and a full left shift. The far datapath covers every other case. It has a full right alignment shift with guard, round and sticky bits, and its normalization afterwards never needs more than one bit of shift in either direction.

A control module classifies the operands. It flags zero operands, works out the effective operation and the operand with the larger magnitude, and picks the path. It passes all of this to the datapath as a small set of strobes. Subnormal operands are read as zero. Results below the normal range are flushed to zero. An exponent overflow gives infinity. The selected result is registered, so it appears one clock after the operands are presented. Operands with an all-ones exponent are outside the supported range.

Top module: `dual_path_fadd`

## Requirements
- R1: While reset is asserted, and at the first clock after it is released, `result` is 32'h0000_0000.
- R2: The result for the operands present at a rising clock edge appears on `result` just after that edge. It stays unchanged until the next edge, and `result` holds steady while the inputs hold steady.
- R3: When the operation is an effective addition, or an effective subtraction with exponents (bits 30:23) that differ by two or more, the result equals the exact sum rounded to nearest-even. This covers alignment shifts larger than the mantissa width.
- R4: For an effective subtraction with exponents that differ by at most one, the result equals the exact difference, normalized over any number of leading zeros and rounded to nearest-even.
- R5: When two nonzero operands of equal magnitude cancel exactly, the result is +0 (32'h0000_0000).
- R6: When exactly one operand is zero, the result is the other operand. A second operand that passes through while `subOp`=1 has its sign bit (bit 31) inverted.
- R7: When both operands are zero, the result is zero with sign 1 only if the first sign and the effective second sign are both 1.
- R8: A result whose exponent would reach 255 becomes infinity (exponent 8'hFF, fraction 0) with the sign of the larger-magnitude operand.
- R9: An exact tie rounds to the even fraction. A carry out of the rounded mantissa raises the exponent by one and clears the fraction.
- R10: An operand with exponent field 0 and a nonzero fraction is treated as zero.
- R11: A nonzero exact result below the smallest normal magnitude becomes zero carrying the sign of the larger-magnitude operand.
- R12: `subOp`=1 computes opA minus opB, which is the same as adding opB with its sign bit inverted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Asynchronous reset, active high, clears the result register |
| opA | input | 32 | First binary32 operand |
| opB | input | 32 | Second binary32 operand |
| subOp | input | 1 | 1 selects opA minus opB, 0 selects opA plus opB |
| result | output | 32 | Registered, rounded binary32 result |

## Verification
Each result is due one rising edge after its operands are applied. The bench changes inputs on the falling edge and samples `result` on the next falling edge, which is exactly one register stage later. For the latency requirement, the bench also samples shortly after a new operand pair is applied and before the next rising edge. At that point `result` must still show the previous answer. Expected values come from a real-number sum that a bench function rounds to binary32. Random operands are weighted toward exponent gaps of zero and one, and directed cases cover ties, rounding carries, overflow, cancellation, flushing and zero operands.

// File: rtl/fadd_pkg.sv
package fadd_pkg;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int WORD_W = 1 + EXP_W + FRAC_W;

  typedef struct packed {
    logic zeroOut;   // both operands read as zero
    logic zeroSign;  // sign for the both-zero case
    logic passA;     // only opB is zero
    logic passB;     // only opA is zero
    logic swap;      // opB has the larger magnitude
    logic effSub;    // signs make this a subtraction
    logic nearSel;   // near datapath owns the result
    logic bNeg;      // effective sign of opB
    logic resSign;   // sign of a nonzero result
  } addStrobes_t;
endpackage

// File: rtl/fadd_ctrl.sv
module fadd_ctrl
  import fadd_pkg::*;
#(
  parameter int EW = EXP_W,
  parameter int FW = FRAC_W,
  localparam int W = 1 + EW + FW
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic         subOp,
  output addStrobes_t  strobes
);
  logic [EW-1:0] expA, expB;
  logic          zeroA, zeroB;
  logic [EW:0]   gapAB, gapBA;
  logic          closeExp, bigB;

  always_comb begin
    expA     = opA[W-2:FW];
    expB     = opB[W-2:FW];
    zeroA    = (expA == '0);
    zeroB    = (expB == '0);
    gapAB    = {1'b0, expA} - {1'b0, expB};
    gapBA    = {1'b0, expB} - {1'b0, expA};
    closeExp = (gapAB <= (EW+1)'(1)) || (gapBA <= (EW+1)'(1));
    bigB     = !zeroB && (zeroA || (opB[W-2:0] > opA[W-2:0]));

    strobes.bNeg     = opB[W-1] ^ subOp;
    strobes.effSub   = opA[W-1] ^ strobes.bNeg;
    strobes.zeroOut  = zeroA && zeroB;
    strobes.zeroSign = opA[W-1] & strobes.bNeg;
    strobes.passA    = zeroB && !zeroA;
    strobes.passB    = zeroA && !zeroB;
    strobes.swap     = bigB;
    strobes.nearSel  = strobes.effSub && closeExp;
    strobes.resSign  = bigB ? strobes.bNeg : opA[W-1];
  end
endmodule

// File: rtl/fadd_near.sv
module fadd_near #(
  parameter int EW = 8,
  parameter int MW = 24,
  localparam int FW  = MW - 1,
  localparam int DW  = MW + 1,
  localparam int LZW = $clog2(DW + 1)
) (
  input  logic [EW-1:0] bigExp,
  input  logic [MW-1:0] bigMant,
  input  logic [MW-1:0] smallMant,
  input  logic          shiftOne,
  output logic [EW-1:0] nearExp,
  output logic [FW-1:0] nearFrac,
  output logic          nearZero,
  output logic          nearUnder
);
  logic [DW-1:0]  subtrahend, dif, norm;
  logic [LZW-1:0] lz;
  logic           found, roundUp;
  logic [FW:0]    fracRnd;
  logic [EW+1:0]  expWide;

  always_comb begin
    // operands were ordered by magnitude, so the difference is never negative
    subtrahend = shiftOne ? {1'b0, smallMant} : {smallMant, 1'b0};
    dif        = {bigMant, 1'b0} - subtrahend;

    lz    = LZW'(DW);
    found = 1'b0;
    for (int i = DW - 1; i >= 0; i--) begin
      if (!found && dif[i]) begin
        lz    = LZW'(DW - 1 - i);
        found = 1'b1;
      end
    end
    norm = dif << lz;

    // only one bit below the kept field and no sticky: a set guard is a tie
    roundUp  = norm[0] & norm[1];
    fracRnd  = {1'b0, norm[FW:1]} + {{FW{1'b0}}, roundUp};
    expWide  = {2'b00, bigExp} - {{(EW+2-LZW){1'b0}}, lz}
             + {{(EW+1){1'b0}}, fracRnd[FW]};
    nearZero  = !norm[DW-1];
    nearUnder = expWide[EW+1] || (expWide[EW:0] == '0);
    nearExp   = expWide[EW-1:0];
    nearFrac  = fracRnd[FW-1:0];
  end
endmodule

// File: rtl/fadd_far.sv
module fadd_far #(
  parameter int EW = 8,
  parameter int MW = 24,
  localparam int FW   = MW - 1,
  localparam int CAP  = MW + 2,
  localparam int WIDE = MW + CAP,
  localparam int XW   = MW + 3
) (
  input  logic [EW-1:0] bigExp,
  input  logic [EW-1:0] expGap,
  input  logic [MW-1:0] bigMant,
  input  logic [MW-1:0] smallMant,
  input  logic          effSub,
  output logic [EW-1:0] farExp,
  output logic [FW-1:0] farFrac,
  output logic          farOvf
);
  logic [EW-1:0]   shAmt;
  logic [WIDE-1:0] wide;
  logic [XW-1:0]   yAl, norm;
  logic [XW:0]     raw;
  logic            incE, decE, roundUp;
  logic [FW:0]     fracRnd;
  logic [EW+1:0]   expWide;
  logic            unusedHidden;

  always_comb begin
    // beyond CAP every bit of the small mantissa lands in the sticky field
    shAmt = (expGap > EW'(CAP)) ? EW'(CAP) : expGap;
    wide  = {smallMant, {CAP{1'b0}}} >> shAmt;
    yAl   = {wide[WIDE-1:CAP], wide[CAP-1], wide[CAP-2], |wide[CAP-3:0]};
    raw   = effSub ? ({1'b0, bigMant, 3'b000} - {1'b0, yAl})
                   : ({1'b0, bigMant, 3'b000} + {1'b0, yAl});

    incE = raw[XW];
    decE = !raw[XW] && !raw[XW-1];
    if (incE)      norm = {raw[XW:2], raw[1] | raw[0]};
    else if (decE) norm = {raw[XW-2:0], 1'b0};
    else           norm = raw[XW-1:0];

    roundUp = norm[2] & (norm[1] | norm[0] | norm[3]);
    fracRnd = {1'b0, norm[XW-2:3]} + {{FW{1'b0}}, roundUp};
    expWide = {2'b00, bigExp} + {{(EW+1){1'b0}}, incE}
            + {{(EW+1){1'b0}}, fracRnd[FW]} - {{(EW+1){1'b0}}, decE};
    farOvf  = expWide >= {2'b00, {EW{1'b1}}};
    farExp  = expWide[EW-1:0];
    farFrac = fracRnd[FW-1:0];
  end

  assign unusedHidden = norm[XW-1];
endmodule

// File: rtl/fadd_datapath.sv
module fadd_datapath
  import fadd_pkg::*;
#(
  parameter int EW = EXP_W,
  parameter int FW = FRAC_W,
  localparam int W  = 1 + EW + FW,
  localparam int MW = FW + 1
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  addStrobes_t  strobes,
  output logic [W-1:0] sum
);
  logic [EW-1:0] bigExp, smallExp, expGap;
  logic [MW-1:0] bigMant, smallMant;
  logic [EW-1:0] nearExp, farExp;
  logic [FW-1:0] nearFrac, farFrac;
  logic          nearZero, nearUnder, farOvf;
  logic          unusedSignB;

  always_comb begin
    if (strobes.swap) begin
      bigExp    = opB[W-2:FW];
      bigMant   = {1'b1, opB[FW-1:0]};
      smallExp  = opA[W-2:FW];
      smallMant = {1'b1, opA[FW-1:0]};
    end else begin
      bigExp    = opA[W-2:FW];
      bigMant   = {1'b1, opA[FW-1:0]};
      smallExp  = opB[W-2:FW];
      smallMant = {1'b1, opB[FW-1:0]};
    end
    expGap = bigExp - smallExp;
  end

  fadd_near #(.EW(EW), .MW(MW)) u_near (
    .bigExp    (bigExp),
    .bigMant   (bigMant),
    .smallMant (smallMant),
    .shiftOne  (expGap[0]),
    .nearExp   (nearExp),
    .nearFrac  (nearFrac),
    .nearZero  (nearZero),
    .nearUnder (nearUnder)
  );

  fadd_far #(.EW(EW), .MW(MW)) u_far (
    .bigExp    (bigExp),
    .expGap    (expGap),
    .bigMant   (bigMant),
    .smallMant (smallMant),
    .effSub    (strobes.effSub),
    .farExp    (farExp),
    .farFrac   (farFrac),
    .farOvf    (farOvf)
  );

  always_comb begin
    if (strobes.zeroOut)      sum = {strobes.zeroSign, {(W-1){1'b0}}};
    else if (strobes.passA)   sum = opA;
    else if (strobes.passB)   sum = {strobes.bNeg, opB[W-2:0]};
    else if (strobes.nearSel) begin
      if (nearZero)           sum = '0;
      else if (nearUnder)     sum = {strobes.resSign, {(W-1){1'b0}}};
      else                    sum = {strobes.resSign, nearExp, nearFrac};
    end
    else if (farOvf)          sum = {strobes.resSign, {EW{1'b1}}, {FW{1'b0}}};
    else                      sum = {strobes.resSign, farExp, farFrac};
  end

  assign unusedSignB = opB[W-1];
endmodule

// File: rtl/dual_path_fadd.sv
module dual_path_fadd
  import fadd_pkg::*;
#(
  parameter int EW = EXP_W,
  parameter int FW = FRAC_W,
  localparam int W = 1 + EW + FW
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic         subOp,
  output logic [W-1:0] result
);
  addStrobes_t  strobes;
  logic [W-1:0] sumNext;

  fadd_ctrl #(.EW(EW), .FW(FW)) u_ctrl (
    .opA     (opA),
    .opB     (opB),
    .subOp   (subOp),
    .strobes (strobes)
  );

  fadd_datapath #(.EW(EW), .FW(FW)) u_dp (
    .opA     (opA),
    .opB     (opB),
    .strobes (strobes),
    .sum     (sumNext)
  );

  always_ff @(posedge clk or posedge rst) begin
    if (rst) result <= '0;
    else     result <= sumNext;
  end
endmodule

// File: rtl/dual_path_fadd_chk.sv
module dual_path_fadd_chk #(
  parameter int W  = 32,
  parameter int EW = 8,
  localparam int FW = W - 1 - EW
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] opA,
  input logic [W-1:0] opB,
  input logic         subOp,
  input logic [W-1:0] result
);
  logic effSubIn;
  assign effSubIn = opA[W-1] ^ opB[W-1] ^ subOp;

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (result == '0));

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $stable(opA) && $stable(opB) && $stable(subOp)) |=> $stable(result));

  p_cancel_r5: assert property (@(posedge clk) disable iff (rst)
    (opA[W-2:FW] != '0 && opA[W-2:0] == opB[W-2:0] && effSubIn) |=> (result == '0));

  p_zero_pass_r6: assert property (@(posedge clk) disable iff (rst)
    (opA[W-2:FW] != '0 && opB[W-2:FW] == '0) |=> (result == $past(opA)));

  p_inf_clean_r8: assert property (@(posedge clk) disable iff (rst)
    (result[W-2:FW] == '1) |-> (result[FW-1:0] == '0));

  p_flush_in_r10: assert property (@(posedge clk) disable iff (rst)
    (opA[W-2:FW] == '0 && opB[W-2:FW] == '0) |=> (result[W-2:0] == '0));
endmodule

bind dual_path_fadd dual_path_fadd_chk #(.W(W), .EW(EW)) u_chk (.*);

// File: tb/dual_path_fadd_tb.sv
`timescale 1ns/1ps
module dual_path_fadd_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] opA = '0, opB = '0;
  logic        subOp = 1'b0;
  logic [31:0] result;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  dual_path_fadd u_dut (.clk(clk), .rst(rst), .opA(opA), .opB(opB), .subOp(subOp), .result(result));

  function automatic real f2r(logic [31:0] f);
    if (f[30:23] == 8'h00) return 0.0;
    return $bitstoreal({f[31], 11'(f[30:23]) + 11'd896, f[22:0], 29'd0});
  endfunction

  function automatic logic [31:0] r2f(real r);
    logic [63:0] d;
    logic [24:0] mr;
    logic        g, st;
    int          e;
    d = $realtobits(r);
    if (d[62:0] == '0) return 32'h0;
    e  = int'(d[62:52]) - 896;
    g  = d[28];
    st = |d[27:0];
    mr = {2'b01, d[51:29]} + ((g && (st || d[29])) ? 25'd1 : 25'd0);
    if (mr[24]) begin e++; mr = mr >> 1; end
    if (e >= 255) return {d[63], 8'hFF, 23'h0};
    if (e <= 0)   return {d[63], 31'h0};
    return {d[63], 8'(e), mr[22:0]};
  endfunction

  function automatic logic [31:0] expectSum(logic [31:0] a, logic [31:0] b, logic s);
    real rb;
    if (a[30:23] == 0 && b[30:23] == 0) return {a[31] & (b[31] ^ s), 31'h0};
    rb = f2r(b);
    if (s) rb = -rb;
    return r2f(f2r(a) + rb);
  endfunction

  function automatic string pickTag(logic [31:0] a, logic [31:0] b, logic s, logic [31:0] e);
    int gap;
    logic eff;
    eff = a[31] ^ b[31] ^ s;
    gap = int'(a[30:23]) - int'(b[30:23]);
    if (a[30:23] == 0 && b[30:23] == 0) return "R7";
    if ((a[30:23] == 0 && a[22:0] != 0) || (b[30:23] == 0 && b[22:0] != 0)) return "R10";
    if (a[30:23] == 0 || b[30:23] == 0) return "R6";
    if (e[30:23] == 8'hFF) return "R8";
    if (eff && a[30:0] == b[30:0]) return "R5";
    if (eff && gap <= 1 && gap >= -1) return "R4";
    return "R3";
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp,
                       input logic [31:0] a, input logic [31:0] b, input logic s);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s a=%h b=%h sub=%b got=%h expected=%h", tag, a, b, s, got, exp);
    end
  endtask

  task automatic runVec(input logic [31:0] a, input logic [31:0] b, input logic s, input string tag);
    logic [31:0] exp;
    @(negedge clk);
    opA = a; opB = b; subOp = s;
    @(negedge clk);
    exp = expectSum(a, b, s);
    check((tag == "") ? pickTag(a, b, s, exp) : tag, result, exp, a, b, s);
  endtask

  function automatic logic [7:0] clampExp(int e);
    if (e < 1) return 8'd1;
    if (e > 254) return 8'd254;
    return 8'(e);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] prevExp;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1", result, 32'h0, opA, opB, subOp);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", result, 32'h0, opA, opB, subOp);

    // R3 far path: effective add, large gaps, gap beyond mantissa width
    runVec(32'h3F800000, 32'h40000000, 1'b0, "R3");
    runVec(32'h4B800000, 32'h3F800000, 1'b1, "R3");
    runVec(32'h3F800000, 32'h2F800000, 1'b0, "R3");
    runVec(32'hC1200000, 32'h3E4CCCCD, 1'b0, "R3");
    // R4 near path with deep cancellation
    runVec(32'h3F800000, 32'h3F7FFFFF, 1'b1, "R4");
    runVec(32'h3F800001, 32'hBF800000, 1'b0, "R4");
    runVec(32'h40490FDB, 32'h40490FD0, 1'b1, "R4");
    // R5 exact cancellation
    runVec(32'h40490FDB, 32'h40490FDB, 1'b1, "R5");
    runVec(32'hC2C80000, 32'h42C80000, 1'b0, "R5");
    // R6 zero operand pass-through, R12 sign flip on the passed operand
    runVec(32'h00000000, 32'h3FC00000, 1'b1, "R6");
    runVec(32'h80000000, 32'hC0A00000, 1'b0, "R6");
    runVec(32'h41200000, 32'h80000000, 1'b1, "R6");
    // R7 both zero
    runVec(32'h80000000, 32'h80000000, 1'b0, "R7");
    runVec(32'h80000000, 32'h00000000, 1'b1, "R7");
    runVec(32'h00000000, 32'h80000000, 1'b0, "R7");
    // R8 overflow to infinity
    runVec(32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, "R8");
    runVec(32'hFF7FFFFF, 32'h7F7FFFFF, 1'b1, "R8");
    // R9 ties to even and rounding carry
    runVec(32'h3F800000, 32'h33800000, 1'b0, "R9");
    runVec(32'h3F800001, 32'h33800000, 1'b0, "R9");
    runVec(32'h3FFFFFFF, 32'h33800000, 1'b0, "R9");
    runVec(32'h3F800001, 32'h3F000000, 1'b1, "R9");
    // R10 subnormal operands read as zero
    runVec(32'h00400000, 32'h3F800000, 1'b0, "R10");
    runVec(32'h40000000, 32'h807FFFFF, 1'b1, "R10");
    // R11 underflow flush keeps sign of larger operand
    runVec(32'h00800001, 32'h00800000, 1'b1, "R11");
    runVec(32'h80800001, 32'h80800000, 1'b1, "R11");
    // R12 subtract equals add of negated operand
    runVec(32'h40400000, 32'h3F800000, 1'b1, "R12");
    runVec(32'h40400000, 32'hBF800000, 1'b0, "R12");

    // R2: the new answer is not visible before the rising edge
    @(negedge clk);
    prevExp = expectSum(32'h40400000, 32'hBF800000, 1'b0);
    opA = 32'h41000000; opB = 32'h40000000; subOp = 1'b0;
    #1;
    check("R2", result, prevExp, opA, opB, subOp);
    @(negedge clk);
    check("R2", result, 32'h41200000, opA, opB, subOp);

    for (int n = 0; n < 4000; n++) begin
      logic [7:0]  ea, eb;
      logic [31:0] a, b;
      int mode;
      ea   = clampExp(1 + int'($urandom % 254));
      mode = int'($urandom % 5);
      case (mode)
        0: eb = ea;
        1: eb = clampExp(int'(ea) + ((($urandom % 2) == 0) ? 1 : -1));
        2: eb = clampExp(int'(ea) - int'($urandom % 30));
        3: eb = clampExp(1 + int'($urandom % 254));
        default: eb = clampExp(int'(ea) - 1);
      endcase
      a = {1'($urandom), ea, 23'($urandom)};
      b = {1'($urandom), eb, 23'($urandom)};
      if (mode == 4) b[22:0] = a[22:0] ^ 23'($urandom % 8);
      runVec(a, b, 1'($urandom), "");
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule